// File: doc/BRIEF.md
# Receive FIFO with Fill-Level Flags

This block buffers received bytes between a serial deserializer and the register interface that reads them. It holds up to 16 bytes in arrival order. The deserializer offers a byte with a one-cycle valid strobe. The reader pops one byte per strobe, and the popped byte appears on a registered data output after the clock edge.

Two fill thresholds act on the stored count. Each is chosen by its own 2-bit code. The first raises a data-available flag once enough bytes are waiting. The second controls a hardware flow-control request line, whose active level can be selected.

A byte that arrives while the FIFO is full is dropped, and a sticky overflow flag records the loss. A synchronous flush input empties the FIFO at once.

Top module: `rxq_fifo`

## Requirements
- R1: After reset, empty=1, full=0, data_avail=0, overflow=0 and rd_data=0, and the RTS line is in its active state.
- R2: A pop returns bytes in the order they were written. rd_data takes the oldest byte at the clock edge on which rd_pop is sampled high.
- R3: A write sampled while full=1 is discarded, even if a pop occurs in the same cycle, and it sets overflow. overflow stays set until ovf_clr is sampled high. If a discarded write and ovf_clr fall in the same cycle, overflow stays set.
- R4: empty is 1 exactly when 0 bytes are stored, and full is 1 exactly when 16 bytes are stored.
- R5: data_avail is 1 exactly when the stored count is greater than or equal to the level selected by avail_lvl. The code 0 selects 1 byte, 1 selects 4, 2 selects 8 and 3 selects 14.
- R6: RTS is active while the stored count is below the level selected by rts_lvl, using the same code as R5. It is inactive once the count reaches that level.
- R7: With rts_low_active=1, active RTS drives rts_o=0 and inactive RTS drives rts_o=1. With rts_low_active=0, the output is the opposite.
- R8: A pop while empty leaves rd_data unchanged and stores nothing.
- R9: A push and a pop in the same cycle on a FIFO that is neither empty nor full leave the count unchanged. The pop returns the oldest byte.
- R10: A flush sampled high empties the FIFO and overrides any push or pop in the same cycle. rd_data is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous flush of all stored bytes |
| wr_valid | input | 1 | Byte strobe from the deserializer |
| wr_data | input | 8 | Byte from the deserializer |
| rd_pop | input | 1 | Pop request from the register reader |
| rd_data | output | 8 | Most recently popped byte |
| avail_lvl | input | 2 | Data-available threshold code |
| rts_lvl | input | 2 | Flow-control threshold code |
| rts_low_active | input | 1 | 1 selects an active-low RTS line |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| empty | output | 1 | No bytes stored |
| full | output | 1 | 16 bytes stored |
| data_avail | output | 1 | Count is at or above the available threshold |
| overflow | output | 1 | Sticky flag for a dropped byte |
| rts_o | output | 1 | Flow-control request line |

## Verification
The bench fills the FIFO one byte at a time, from 0 to 16 entries. At every fill level it sweeps all 16 combinations of the two threshold codes under both RTS polarities. This separates an off-by-one in the compare, such as greater-than used where greater-or-equal is needed, and it also catches a swapped code table or an inverted polarity.

Draining the FIFO with distinct byte values shows whether bytes come out in order and whether a write made while full was really discarded. Further directed patterns cover the remaining paths:
- a simultaneous push and pop, followed by a counted drain;
- a pop while empty;
- a flush that coincides with a write;
- an overflow clear that coincides with a new overflow.

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  input  logic [1:0]    avail_lvl,
  input  logic [1:0]    rts_lvl,
  input  logic          rts_low_active,
  input  logic          ovf_clr,
  output logic          empty,
  output logic          full,
  output logic          data_avail,
  output logic          overflow,
  output logic          rts_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push, pop, rts_act;

  function automatic logic [CW-1:0] lvl(input logic [1:0] code);
    case (code)
      2'd0:    lvl = CW'(1);
      2'd1:    lvl = CW'(4);
      2'd2:    lvl = CW'(8);
      default: lvl = CW'(14);
    endcase
  endfunction

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    nxt = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty      = (cnt == '0);
  assign full       = (cnt == CW'(DEPTH));
  assign push       = wr_valid & ~full & ~flush;
  assign pop        = rd_pop & ~empty & ~flush;
  assign data_avail = (cnt >= lvl(avail_lvl));
  assign rts_act    = (cnt < lvl(rts_lvl));
  assign rts_o      = rts_act ^ rts_low_active;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      rd_data <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop) begin
        rp      <= nxt(rp);
        rd_data <= mem[rp];
      end
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 overflow <= 1'b0;
    else if (wr_valid && full)  overflow <= 1'b1;
    else if (ovf_clr)           overflow <= 1'b0;
  end
endmodule

module rxq_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flush,
  input logic       wr_valid,
  input logic       rd_pop,
  input logic       ovf_clr,
  input logic       rts_low_active,
  input logic       empty,
  input logic       full,
  input logic       data_avail,
  input logic       overflow,
  input logic       rts_o,
  input logic [7:0] rd_data
);
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && full |=> overflow);
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !ovf_clr |=> overflow);
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && full && !rd_pop && !flush |=> full);
  p_empty_pop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop && empty |=> $stable(rd_data));
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  p_avail_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_avail |-> !empty);
  p_rts_full_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (rts_o == rts_low_active));
  p_rts_empty_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (rts_o == !rts_low_active));
endmodule

bind rxq_fifo rxq_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .wr_valid(wr_valid),
  .rd_pop(rd_pop), .ovf_clr(ovf_clr), .rts_low_active(rts_low_active),
  .empty(empty), .full(full), .data_avail(data_avail),
  .overflow(overflow), .rts_o(rts_o), .rd_data(rd_data)
);

// File: tb/sim_rxq_fifo.sv
module sim_rxq_fifo;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0, flush = 0, wr_valid = 0, rd_pop = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] avail_lvl = 0, rts_lvl = 0;
  logic       rts_low_active = 0, ovf_clr = 0;
  logic [7:0] rd_data;
  logic       empty, full, data_avail, overflow, rts_o;

  int  errors = 0, checks = 0;
  logic [7:0] q[$];
  logic [7:0] last_rd = 0;
  logic       m_ovf = 0;

  rxq_fifo u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lv(input int c);
    return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk_flags(input string req);
    chk(empty == (q.size() == 0), {req, " empty"}, int'(empty), int'(q.size() == 0));
    chk(full == (q.size() == 16), {req, " full"}, int'(full), int'(q.size() == 16));
    chk(overflow == m_ovf, {req, " overflow"}, int'(overflow), int'(m_ovf));
  endtask

  task automatic push(input logic [7:0] b);
    wr_valid = 1; wr_data = b;
    step();
    wr_valid = 0;
    if (q.size() < 16) q.push_back(b); else m_ovf = 1;
  endtask

  task automatic pop_chk(input string req);
    rd_pop = 1;
    step();
    rd_pop = 0;
    if (q.size() > 0) last_rd = q.pop_front();
    chk(rd_data == last_rd, req, int'(rd_data), int'(last_rd));
    chk_flags(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    rst_n = 1;
    step();
    // R1 reset state
    chk_flags("R1");
    chk(data_avail == 0, "R1 data_avail", int'(data_avail), 0);
    chk(rd_data == 0, "R1 rd_data", int'(rd_data), 0);
    chk(rts_o == 1, "R1 rts_o", int'(rts_o), 1);

    // R5 R6 R7 sweep over every fill level, threshold code and polarity
    for (int n = 0; n <= 16; n++) begin
      if (n > 0) push(8'(n * 7 + 3));
      chk_flags("R4");
      for (int a = 0; a < 4; a++)
        for (int r = 0; r < 4; r++)
          for (int p = 0; p < 2; p++) begin
            avail_lvl = 2'(a); rts_lvl = 2'(r); rts_low_active = p[0];
            #1;
            chk(data_avail == (n >= lv(a)), "R5", int'(data_avail), int'(n >= lv(a)));
            chk(rts_o == ((n < lv(r)) ^ p[0]), "R6/R7", int'(rts_o), int'((n < lv(r)) ^ p[0]));
          end
    end
    rts_low_active = 0;

    // R3 drop on full, sticky, set beats clear
    push(8'hEE);
    chk_flags("R3 drop");
    wr_valid = 1; wr_data = 8'hDD; ovf_clr = 1;
    step();
    wr_valid = 0; ovf_clr = 0;
    chk_flags("R3 set over clear");
    ovf_clr = 1; step(); ovf_clr = 0; m_ovf = 0;
    chk_flags("R3 clear");

    // R2 drain in order, discarded bytes must not appear
    while (q.size() > 0) pop_chk("R2");

    // R8 pop when empty
    pop_chk("R8");
    pop_chk("R8 again");

    // R9 simultaneous push and pop
    for (int i = 0; i < 5; i++) push(8'(8'h40 + i));
    wr_valid = 1; wr_data = 8'h99; rd_pop = 1;
    step();
    wr_valid = 0; rd_pop = 0;
    last_rd = q.pop_front(); q.push_back(8'h99);
    chk(rd_data == last_rd, "R9 data", int'(rd_data), int'(last_rd));
    for (int i = 0; i < 5; i++) pop_chk("R9 drain");
    chk(empty == 1, "R9 count", int'(empty), 1);

    // R10 flush overrides push
    for (int i = 0; i < 3; i++) push(8'(8'h70 + i));
    flush = 1; wr_valid = 1; wr_data = 8'h55; rd_pop = 1;
    step();
    flush = 0; wr_valid = 0; rd_pop = 0;
    q.delete();
    chk_flags("R10");
    chk(rd_data == last_rd, "R10 rd_data", int'(rd_data), int'(last_rd));
    pop_chk("R10 after");
    push(8'h12);
    pop_chk("R10 restart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule